// File: doc/BRIEF.md
# Converter Power-Up Mode Sequencer

This block controls a multichannel audio converter from the release of reset until the converter is running. After reset it counts frames of the left/right sample clock. The length of that wait depends on the speed mode. A control write in the wait moves the converter into software mode. If no such write comes before the wait ends, the converter commits to hardware mode: it takes its configuration from four strap inputs and starts powering up on its own.

In software mode the power-down bit decides what happens. The converter stays in its low-power state while that bit is set. Clearing the bit starts a timed power-up, after which the ready flag rises. Setting the bit again drops the converter back to low power. The enable write may also arrive after the hardware power-up has started, and it still moves the converter to software mode.

The control register is written through a plain strobe/address/data port. It holds only two bits: the control enable and the power-down bit.

Top module: `pwrup_mode_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values from the next edge on: `low_power`=1, `ref_en`=0, `ready`=0, `ctl_mode`=0, `strap_cfg`=0. The control enable bit resets to 0 and the power-down bit resets to 1.
- R2: The hardware-mode timeout counts rising edges of `lrck`. It is FRAME_BASE frames when `speed`=2'b00, 2×FRAME_BASE when `speed`=2'b01, and 4×FRAME_BASE when `speed` is 2'b10 or 2'b11. `speed` is captured while reset is held and is ignored after release.
- R3: If the timeout completes with no enable write, the block enters hardware mode. `ctl_mode` stays 0, `strap_cfg` shows the `strap` value captured at the timeout, `low_power` falls and `ref_en` rises.
- R4: A write with `wr_addr`=CTRL_ADDR and `wr_data[1]`=1 before the timeout sets `ctl_mode`=1. While the power-down bit (`wr_data[0]`) is 1, the block stays in low power (`low_power`=1, `ref_en`=0) however many frames follow.
- R5: An enable write after the hardware power-up has begun, or after it has finished, still switches the block to software mode. If the power-down bit is 1, `ready` drops, `low_power` rises and `strap_cfg` reads 0.
- R6: In software mode, clearing the power-down bit raises `ref_en` at once. `ready` rises only after PWRUP_CYCLES clock cycles in the power-up state.
- R7: In software mode, setting the power-down bit back to 1 while running returns the block to low power and clears `ready`.
- R8: Writes to any address other than CTRL_ADDR have no effect.
- R9: Software mode holds until reset. Writing the enable bit back to 0 does not return the block to hardware mode.
- R10: `ready` is high only when `ref_en` is high and `low_power` is low. `ref_en` and `low_power` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the device reset |
| lrck | input | 1 | Left/right sample clock, asynchronous to clk |
| speed | input | 2 | Speed mode, captured during reset |
| strap | input | 4 | Pin-strapped hardware configuration |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 2 | Write data: bit 1 control enable, bit 0 power-down |
| low_power | output | 1 | Converter held in low-power state |
| ctl_mode | output | 1 | 1 = software mode, 0 = hardware mode |
| strap_cfg | output | 4 | Strap configuration in effect in hardware mode, else 0 |
| ref_en | output | 1 | Reference enable, high from power-up start |
| ready | output | 1 | Power-up complete, converter operational |

## Verification
The assertions check on every cycle the relations among the outputs that must always hold. `ready` implies an active reference, low power excludes the reference, software mode never reverts, reset forces the idle outputs, and `ready` only rises after a cycle with the reference enabled. Some behaviour depends on counts and on the race between a late enable write and the frame timeout, which only the bench scenarios can show. These are the exact timeout length for each speed, the strap capture, the length of the power-up timer, and the late switch from hardware to software mode.

// File: rtl/pwrup_pkg.sv
// Shared types for the power-up mode sequencer.
// Assumes: speed codes are 00 single, 01 double, 1x quad.
package pwrup_pkg;
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_PWRUP  = 2'd1,
        ST_RUN    = 2'd2,
        ST_LOWPWR = 2'd3
    } seq_state_t;

    localparam logic [1:0] SPD_SINGLE = 2'b00;
    localparam logic [1:0] SPD_DOUBLE = 2'b01;
endpackage

// File: rtl/lrck_frame_counter.sv
// Counts frames of the left/right clock in the system clock domain and
// flags when the speed-dependent frame limit has been reached.
// Assumes: lrck is asynchronous and slower than clk/4; the speed code is
// stable while rst_n is low and is frozen on release.
module lrck_frame_counter
    import pwrup_pkg::*;
#(
    parameter int FRAME_BASE = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck,
    input  logic [1:0] speed,
    input  logic       count_en,
    output logic       timeout
);
    localparam int CNT_W = $clog2(FRAME_BASE * 4) + 1;

    logic [2:0]       sync_q;
    logic [1:0]       spd_q;
    logic [CNT_W-1:0] frame_cnt;
    logic [CNT_W-1:0] limit;
    logic             rise;

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], lrck};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    // Speed code follows the input during reset, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) spd_q <= speed;
    end

    // Frame limit selected from the captured speed mode.
    always_comb begin
        if (spd_q == SPD_SINGLE)      limit = CNT_W'(FRAME_BASE);
        else if (spd_q == SPD_DOUBLE) limit = CNT_W'(FRAME_BASE * 2);
        else                          limit = CNT_W'(FRAME_BASE * 4);
    end

    // Saturating frame counter, active only in the wait window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (count_en && rise && frame_cnt < limit)
            frame_cnt <= frame_cnt + 1'b1;
    end

    assign timeout = (frame_cnt >= limit);
endmodule

// File: rtl/pwrup_ctrl_regs.sv
// Two-bit control register: control-port enable and power-down.
// Assumes: single write port, no read-back; power-down resets to 1.
module pwrup_ctrl_regs #(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_data,
    output logic              cp_en,
    output logic              pdn
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_ADDR);

    // Capture enable and power-down on a write to the control address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_en <= 1'b0;
            pdn   <= 1'b1;
        end else if (wr_en && wr_addr == MY_ADDR) begin
            cp_en <= wr_data[1];
            pdn   <= wr_data[0];
        end
    end
endmodule

// File: rtl/pwrup_timer.sv
// Counts system clocks during power-up and flags completion.
// Assumes: PWRUP_CYCLES >= 2; clr holds the count at zero.
module pwrup_timer #(
    parameter int PWRUP_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int TW = $clog2(PWRUP_CYCLES) + 1;
    localparam logic [TW-1:0] LAST = TW'(PWRUP_CYCLES - 1);

    logic [TW-1:0] cnt;

    // Free-running count while enabled, holding at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/pwrup_mode_seq.sv
// Power-up mode sequencer: races a frame timeout against a control-port
// enable write, then sequences power-up in hardware or software mode.
// Assumes: synchronous active-low reset; lrck asynchronous to clk.
module pwrup_mode_seq
    import pwrup_pkg::*;
#(
    parameter int FRAME_BASE   = 512,
    parameter int PWRUP_CYCLES = 5000,
    parameter int ADDR_W       = 4,
    parameter int CTRL_ADDR    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lrck,
    input  logic [1:0]        speed,
    input  logic [3:0]        strap,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_data,
    output logic              low_power,
    output logic              ctl_mode,
    output logic [3:0]        strap_cfg,
    output logic              ref_en,
    output logic              ready
);
    seq_state_t state;
    logic       sw_q;
    logic [3:0] strap_q;
    logic       cp_en, pdn, timeout, tmr_done, go_sw, tmr_clr;

    pwrup_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cp_en(cp_en), .pdn(pdn)
    );

    lrck_frame_counter #(.FRAME_BASE(FRAME_BASE)) u_frames (
        .clk(clk), .rst_n(rst_n), .lrck(lrck), .speed(speed),
        .count_en(state == ST_WAIT), .timeout(timeout)
    );

    // Switch to software mode whenever the enable is seen in hardware mode.
    assign go_sw   = cp_en && !sw_q;
    assign tmr_clr = (state != ST_PWRUP) || go_sw;

    pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .done(tmr_done)
    );

    // Mode and power-state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT;
            sw_q    <= 1'b0;
            strap_q <= '0;
        end else if (go_sw) begin
            sw_q    <= 1'b1;
            strap_q <= '0;
            state   <= pdn ? ST_LOWPWR : ST_PWRUP;
        end else if (state == ST_WAIT) begin
            if (timeout) begin
                strap_q <= strap;
                state   <= ST_PWRUP;
            end
        end else if (sw_q && pdn) begin
            state <= ST_LOWPWR;
        end else if (state == ST_LOWPWR && sw_q) begin
            state <= ST_PWRUP;
        end else if (state == ST_PWRUP && tmr_done) begin
            state <= ST_RUN;
        end
    end

    assign low_power = (state == ST_WAIT) || (state == ST_LOWPWR);
    assign ref_en    = (state == ST_PWRUP) || (state == ST_RUN);
    assign ready     = (state == ST_RUN);
    assign ctl_mode  = sw_q;
    assign strap_cfg = strap_q;
endmodule

// File: rtl/pwrup_mode_seq_chk.sv
// Output-relation checker for the power-up mode sequencer, bound to the top.
module pwrup_mode_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic low_power,
    input logic ctl_mode,
    input logic ref_en,
    input logic ready
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (low_power && !ref_en && !ready && !ctl_mode));

    // R10
    ready_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ref_en && !low_power));

    // R10
    lp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_power && ref_en));

    // R9
    sw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode |=> ctl_mode);

    // R6
    ready_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ref_en));
endmodule

bind pwrup_mode_seq pwrup_mode_seq_chk u_chk (.*);

// File: tb/tb_pwrup_mode_seq.sv
module tb_pwrup_mode_seq;
    localparam int FB = 8;
    localparam int PW = 20;
    localparam int AW = 4;
    localparam int CA = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lrck = 1'b0;
    logic [1:0]    speed = 2'b00;
    logic [3:0]    strap = 4'h0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [1:0]    wr_data = '0;
    logic          low_power, ctl_mode, ref_en, ready;
    logic [3:0]    strap_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    pwrup_mode_seq #(.FRAME_BASE(FB), .PWRUP_CYCLES(PW), .ADDR_W(AW), .CTRL_ADDR(CA)) dut (
        .clk(clk), .rst_n(rst_n), .lrck(lrck), .speed(speed), .strap(strap),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .low_power(low_power), .ctl_mode(ctl_mode), .strap_cfg(strap_cfg),
        .ref_en(ref_en), .ready(ready)
    );

    typedef struct packed { logic [1:0] spd; logic [3:0] st; } vec_t;
    localparam vec_t VECS [4] = '{
        '{spd: 2'b00, st: 4'hA}, '{spd: 2'b01, st: 4'h5},
        '{spd: 2'b10, st: 4'h3}, '{spd: 2'b11, st: 4'hC}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] spd);
        @(negedge clk);
        rst_n = 1'b0;
        speed = spd;
        clks(4);
        rst_n = 1'b1;
        speed = ~spd;
        clks(2);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            lrck = 1'b1; clks(4);
            lrck = 1'b0; clks(4);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        clks(3);
    endtask

    function automatic int lim(input logic [1:0] s);
        return (s == 2'b00) ? FB : (s == 2'b01) ? 2 * FB : 4 * FB;
    endfunction

    initial begin
        // R1 reset state
        do_reset(2'b00);
        check(low_power && !ref_en && !ready && !ctl_mode && strap_cfg == 0,
              "R1 reset outputs", {low_power, ref_en, ready, ctl_mode}, 4'b1000);

        // R2/R3 timeout per speed and strap capture
        foreach (VECS[k]) begin
            strap = VECS[k].st;
            do_reset(VECS[k].spd);
            frames(lim(VECS[k].spd) - 1);
            clks(4);
            check(low_power && !ref_en, "R2 still waiting one frame early", ref_en, 0);
            frames(1);
            clks(4);
            check(ref_en && !low_power && !ctl_mode, "R2 timeout reached", ref_en, 1);
            strap = ~VECS[k].st;
            clks(2);
            check(strap_cfg == VECS[k].st, "R3 strap captured", strap_cfg, VECS[k].st);
        end

        // R3 hardware power-up completes
        clks(PW + 4);
        check(ready == 1'b1, "R3 hardware ready", ready, 1);

        // R4 enable before timeout, power-down held
        do_reset(2'b00);
        frames(3);
        wr(CA[AW-1:0], 2'b11);
        check(ctl_mode == 1'b1, "R4 software mode", ctl_mode, 1);
        frames(3 * FB);
        clks(4);
        check(low_power && !ref_en, "R4 stays low power", low_power, 1);

        // R8 other address ignored
        wr(AW'(CA + 1), 2'b10);
        clks(4);
        check(low_power && !ref_en, "R8 foreign address ignored", ref_en, 0);

        // R6 clear power-down
        wr(CA[AW-1:0], 2'b10);
        check(ref_en && !low_power && !ready, "R6 ref up, not ready", {ref_en, ready}, 2'b10);
        clks(PW - 6);
        check(!ready, "R6 ready not early", ready, 0);
        clks(8);
        check(ready, "R6 ready after timer", ready, 1);
        check(ready && ref_en && !low_power, "R10 ready relation", low_power, 0);

        // R7 set power-down again
        wr(CA[AW-1:0], 2'b11);
        check(low_power && !ready && !ref_en, "R7 back to low power", ready, 0);

        // R9 enable cleared keeps software mode
        wr(CA[AW-1:0], 2'b01);
        check(ctl_mode == 1'b1, "R9 software mode sticky", ctl_mode, 1);

        // R5 late enable after hardware sequence ran
        strap = 4'h9;
        do_reset(2'b00);
        frames(FB);
        clks(PW + 8);
        check(ready && !ctl_mode, "R5 hardware running first", ready, 1);
        wr(CA[AW-1:0], 2'b11);
        check(ctl_mode && low_power && !ready && strap_cfg == 0,
              "R5 late switch to software", {ctl_mode, low_power, ready}, 3'b110);

        // R5 late enable during hardware power-up with power-down cleared
        do_reset(2'b00);
        frames(FB);
        clks(6);
        wr(CA[AW-1:0], 2'b10);
        check(ctl_mode && ref_en && !ready, "R5 switch mid power-up", ctl_mode, 1);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule